// File: doc/BRIEF.md
# Early-Decision Three-Operand Sum Comparator

This block compares two sums of three unsigned operands each. It takes six operands of `W` bits. Each cycle it may accept a new set. A fixed number of cycles later it reports one bit that is high when the left sum (`op_a + op_b + op_c`) is greater than or equal to the right sum (`op_d + op_e + op_f`). The path is pipelined: operand registers, then registered sums, then a registered result.

To save switching power, a small predictor looks only at the six most significant bits as they arrive. Suppose all three left operands have the top bit set and none of the right ones do. The left sum is then at least 3·2^(W-1) and the right sum is below that, so the answer is already 1. The mirrored pattern makes the answer 0. In either case the operand registers and the sum registers are not loaded. The adders and the magnitude compare therefore see no new data. The predicted answer travels down a short side pipeline and overrides the compare at the output.

A design that needs this compare at a steady rate places it inline and reads `out_ge` when `out_valid` is high. `out_predicted` tells whether the result was decided early.

Top module: `sum_cmp_precomp`

## Requirements
- R1: For every accepted operand set, `out_ge` is 1 exactly when op_a+op_b+op_c >= op_d+op_e+op_f, with all values taken as unsigned integers.
- R2: `out_valid` is high in the cycle that follows the third rising clock edge after an edge that sampled `in_valid` high. It is low for sets sampled with `in_valid` low.
- R3: Each sum is held in W+2 bits. The largest operands (all ones on every input) must still compare correctly, with no wrap-around.
- R4: When the top bits of op_a, op_b and op_c are all 1 and the top bits of op_d, op_e and op_f are all 0, the result is `out_ge` = 1 and `out_predicted` = 1.
- R5: When the top bits of op_a, op_b and op_c are all 0 and the top bits of op_d, op_e and op_f are all 1, the result is `out_ge` = 0 and `out_predicted` = 1.
- R6: For any other pattern of top bits, `out_predicted` is 0 and the result comes from the full sums.
- R7: In a cycle where an accepted set is decided early, the operand registers and the sum registers keep their previous contents.
- R8: Equal sums give `out_ge` = 1.
- R9: While `rst_n` is low, `out_valid`, `out_ge` and `out_predicted` are 0.
- R10: A cycle with `in_valid` low loads nothing into the operand registers and produces no valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Operand set on the op_* inputs is to be compared |
| op_a | input | W | Left operand 1 |
| op_b | input | W | Left operand 2 |
| op_c | input | W | Left operand 3 |
| op_d | input | W | Right operand 1 |
| op_e | input | W | Right operand 2 |
| op_f | input | W | Right operand 3 |
| out_valid | output | 1 | out_ge and out_predicted carry a new result |
| out_ge | output | 1 | Left sum is greater than or equal to right sum |
| out_predicted | output | 1 | Result was decided from the top bits alone |

## Verification
Every result is due three rising edges after the edge that accepts its operands. The bench drives at the falling edge and keeps a three-deep queue of expected results. At each falling edge it compares the outputs against the entry that entered the queue three falling edges earlier. Idle cycles push an entry that expects `out_valid` low. The expected value, the predicted flag and the valid flag are therefore checked in the same cycle, whether or not a set was decided early.

// File: rtl/sumcmp_pkg.sv
package sumcmp_pkg;

  // Number of clock edges from operand capture to a visible result.
  localparam int unsigned LATENCY = 3;

  typedef enum logic [1:0] {
    PRED_NONE = 2'd0,
    PRED_HI   = 2'd1,
    PRED_LO   = 2'd2
  } pred_e;

  // msb = {a, b, c, d, e, f} top bits.
  function automatic pred_e classify(input logic [5:0] msb);
    if (msb == 6'b111_000)      return PRED_HI;
    else if (msb == 6'b000_111) return PRED_LO;
    else                        return PRED_NONE;
  endfunction

endpackage

// File: rtl/scp_predictor.sv
module scp_predictor
  import sumcmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic [W-1:0] e,
  input  logic [W-1:0] f,
  output pred_e        pred
);

  localparam int unsigned TOP = W - 1;

  logic [5:0] msb;

  always_comb begin
    msb  = {a[TOP], b[TOP], c[TOP], d[TOP], e[TOP], f[TOP]};
    pred = classify(msb);
  end

endmodule

// File: rtl/scp_operand_bank.sv
module scp_operand_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_OPS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic [N_OPS-1:0][W-1:0]   d,
  output logic [N_OPS-1:0][W-1:0]   q
);

  for (genvar i = 0; i < N_OPS; i++) begin : g_slot
    logic [W-1:0] slot_d;
    logic [W-1:0] slot_q;

    always_comb begin
      slot_d = load_en ? d[i] : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign q[i] = slot_q;
  end

endmodule

// File: rtl/scp_sum3.sv
module scp_sum3 #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  output logic [W+1:0]   sum
);

  localparam int unsigned SW = W + 2;

  logic [SW-1:0] ax, bx, cx;

  always_comb begin
    ax  = {2'b00, a};
    bx  = {2'b00, b};
    cx  = {2'b00, c};
    sum = ax + bx + cx;
  end

  // R3: a wrapped sum would fall below one of its addends
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sum >= ax) && (sum >= bx) && (sum >= cx) && ((sum - ax) >= bx));

endmodule

// File: rtl/sum_cmp_precomp.sv
module sum_cmp_precomp
  import sumcmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  input  logic [W-1:0] op_f,
  output logic         out_valid,
  output logic         out_ge,
  output logic         out_predicted
);

  localparam int unsigned N_OPS = 6;
  localparam int unsigned SW    = W + 2;

  // ---------------- stage 0: predictor on arriving top bits
  pred_e pred_in;

  scp_predictor #(.W(W)) u_pred (
    .a(op_a), .b(op_b), .c(op_c),
    .d(op_d), .e(op_e), .f(op_f),
    .pred(pred_in)
  );

  logic                    opnd_le;
  logic [N_OPS-1:0][W-1:0] opnd_d;
  logic [N_OPS-1:0][W-1:0] opnd_q;

  always_comb begin
    opnd_le = in_valid && (pred_in == PRED_NONE);
    opnd_d  = {op_a, op_b, op_c, op_d, op_e, op_f};
  end

  // ---------------- stage 1: operand registers (gated) and side pipe
  scp_operand_bank #(.W(W), .N_OPS(N_OPS)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(opnd_le),
    .d(opnd_d), .q(opnd_q)
  );

  logic  v1_d, v1_q;
  pred_e p1_d, p1_q;

  always_comb begin
    v1_d = in_valid;
    p1_d = in_valid ? pred_in : PRED_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      p1_q <= PRED_NONE;
    end else begin
      v1_q <= v1_d;
      p1_q <= p1_d;
    end
  end

  // ---------------- adders on frozen-or-fresh operands
  logic [SW-1:0] sum_l, sum_r;

  scp_sum3 #(.W(W)) u_sum_l (
    .clk(clk), .rst_n(rst_n),
    .a(opnd_q[5]), .b(opnd_q[4]), .c(opnd_q[3]),
    .sum(sum_l)
  );

  scp_sum3 #(.W(W)) u_sum_r (
    .clk(clk), .rst_n(rst_n),
    .a(opnd_q[2]), .b(opnd_q[1]), .c(opnd_q[0]),
    .sum(sum_r)
  );

  // ---------------- stage 2: sum registers (gated) and side pipe
  logic          sum_le;
  logic [SW-1:0] sl_d, sr_d, sl_q, sr_q;
  logic          v2_d, v2_q;
  pred_e         p2_d, p2_q;

  always_comb begin
    sum_le = v1_q && (p1_q == PRED_NONE);
    sl_d   = sum_le ? sum_l : sl_q;
    sr_d   = sum_le ? sum_r : sr_q;
    v2_d   = v1_q;
    p2_d   = v1_q ? p1_q : PRED_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_q <= '0;
      sr_q <= '0;
      v2_q <= 1'b0;
      p2_q <= PRED_NONE;
    end else begin
      sl_q <= sl_d;
      sr_q <= sr_d;
      v2_q <= v2_d;
      p2_q <= p2_d;
    end
  end

  // ---------------- stage 3: compare, override, output register
  logic cmp_ge;
  logic ge_d, pr_d, ov_d;
  logic ge_q, pr_q, ov_q;

  always_comb begin
    cmp_ge = (sl_q >= sr_q);
    ov_d   = v2_q;
    ge_d   = ge_q;
    pr_d   = pr_q;
    if (v2_q) begin
      unique case (p2_q)
        PRED_HI: begin ge_d = 1'b1;   pr_d = 1'b1; end
        PRED_LO: begin ge_d = 1'b0;   pr_d = 1'b1; end
        default: begin ge_d = cmp_ge; pr_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ge_q <= 1'b0;
      pr_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      ge_q <= ge_d;
      pr_q <= pr_d;
    end
  end

  assign out_valid     = ov_q;
  assign out_ge        = ge_q;
  assign out_predicted = pr_q;

  // ---------------- assertions
  logic [1:0] rst_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rst_age <= 2'd0;
    else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
  end

  // R2: fixed three-edge latency of the valid flag
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R7: an early-decided set leaves the operand registers untouched
  a_r7_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pred_in != PRED_NONE)) |=> $stable(opnd_q));

  // R7: and the sum registers one stage later
  a_r7_sums_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && (p1_q != PRED_NONE)) |=> ($stable(sl_q) && $stable(sr_q)));

  // R10: idle cycles load nothing
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(opnd_q));

  // R4: a high prediction at stage 2 yields a predicted 1
  a_r4_hi_forces_one: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (p2_q == PRED_HI)) |=> (out_ge && out_predicted && out_valid));

  // R5: a low prediction at stage 2 yields a predicted 0
  a_r5_lo_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (p2_q == PRED_LO)) |=> (!out_ge && out_predicted && out_valid));

  // R6: a result not predicted never reports the predicted flag
  a_r6_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (p2_q == PRED_NONE)) |=> !out_predicted);

endmodule

// File: tb/sum_cmp_precomp_tb.sv
module sum_cmp_precomp_tb;

  localparam int W    = 2;
  localparam int MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] op_a, op_b, op_c, op_d, op_e, op_f;
  logic         out_valid, out_ge, out_predicted;

  int checks;
  int errors;
  bit done;

  // expected pipeline, index 2 is due at the current falling edge
  logic  ev [3];
  logic  eg [3];
  logic  ep [3];
  string et [3];

  sum_cmp_precomp #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .op_d(op_d), .op_e(op_e), .op_f(op_f),
    .out_valid(out_valid), .out_ge(out_ge), .out_predicted(out_predicted)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int a, input int b, input int c,
                      input int d, input int e, input int f);
    int  ls, rs;
    bit  hi, lo;
    string tag;
    @(negedge clk);
    // compare the result due now
    if (ev[2]) begin
      check({"R2 valid ", et[2]}, out_valid, 1'b1);
      check({et[2], " ge"}, out_ge, eg[2]);
      check({(ep[2] ? "R4/R5" : "R6"), " predicted ", et[2]}, out_predicted, ep[2]);
    end else begin
      check("R10 idle gives no valid", out_valid, 1'b0);
    end
    ev[2] = ev[1]; eg[2] = eg[1]; ep[2] = ep[1]; et[2] = et[1];
    ev[1] = ev[0]; eg[1] = eg[0]; ep[1] = ep[0]; et[1] = et[0];
    // expected result for the new set, from the requirements
    ls  = a + b + c;
    rs  = d + e + f;
    hi  = (a > MAXV/2) && (b > MAXV/2) && (c > MAXV/2) &&
          (d <= MAXV/2) && (e <= MAXV/2) && (f <= MAXV/2);
    lo  = (a <= MAXV/2) && (b <= MAXV/2) && (c <= MAXV/2) &&
          (d > MAXV/2) && (e > MAXV/2) && (f > MAXV/2);
    if (hi)                    tag = "R4";
    else if (lo)               tag = "R5";
    else if (ls == rs)         tag = "R8";
    else if (ls == 3 * MAXV)   tag = "R3";
    else                       tag = "R1";
    ev[0] = v;
    eg[0] = (ls >= rs);
    ep[0] = hi || lo;
    et[0] = tag;
    in_valid = v;
    op_a = W'(a); op_b = W'(b); op_c = W'(c);
    op_d = W'(d); op_e = W'(e); op_f = W'(f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    for (int i = 0; i < 3; i++) begin ev[i] = 0; eg[i] = 0; ep[i] = 0; et[i] = "-"; end
    rst_n = 1'b0; in_valid = 1'b0;
    op_a = '0; op_b = '0; op_c = '0; op_d = '0; op_e = '0; op_f = '0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", out_valid, 1'b0);
    check("R9 reset out_ge", out_ge, 1'b0);
    check("R9 reset out_predicted", out_predicted, 1'b0);
    rst_n = 1'b1;

    // directed corners
    step(1, 2, 2, 2, 1, 1, 1);             // R4 predictor high
    step(1, 1, 0, 1, 3, 2, 3);             // R5 predictor low
    step(1, 3, 0, 1, 2, 2, 0);             // R8 equal sums, no prediction
    step(1, MAXV, MAXV, MAXV, MAXV, MAXV, MAXV); // R3 largest, equal
    step(1, MAXV, MAXV, MAXV, MAXV, MAXV, 0);    // R3 largest left, no prediction
    step(0, 3, 3, 3, 0, 0, 0);             // R10 idle with a predictable pattern
    step(1, 0, 0, 0, 0, 0, 1);             // R1 left smaller
    step(1, 2, 2, 2, 0, 0, 0);             // R4 then R7 with held operands
    step(1, 0, 1, 0, 1, 0, 0);             // R6 after a frozen cycle: R7 freeze harmless

    // exhaustive sweep with periodic idle cycles (R1, R6, R10)
    for (int idx = 0; idx < (1 << (6 * W)); idx++) begin
      if (idx % 7 == 3) step(0, (idx >> 1) & MAXV, 0, MAXV, 0, 1, MAXV);
      step(1, (idx >> (5*W)) & MAXV, (idx >> (4*W)) & MAXV, (idx >> (3*W)) & MAXV,
              (idx >> (2*W)) & MAXV, (idx >> W) & MAXV, idx & MAXV);
    end
    // drain
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule